// File: doc/BRIEF.md
# Dual-Format Transmit Serializer

This block takes 8b/10b-encoded transmit symbols from a protocol device and sends them out one bit per bit-clock cycle. The parallel side has two formats, picked by a format input. In full-word format, a 10-bit symbol is presented once per word period and sampled at the word-rate strobe. In half-word format, only the five low data lines carry data. The low half of the symbol is sampled at the word-rate strobe. The high half is sampled at the mid-word point, which stands for the opposite edge of the reference clock.

The whole block runs on the bit clock. The rising edge of the reference clock appears as the one-cycle strobe `ref_rise`. An internal phase counter re-aligns to that strobe and marks the mid-word point five cycles later. A finished word moves into the shift register only on a word-rate strobe. In half-word format the assembled word passes through one extra word stage, so that its two halves always leave together.

A loopback control sends the serial stream to a receive-side output and turns off the external line driver. The driver is modelled as an output-enable flag, with the data forced low while that flag is off. A global enable turns off both serial paths.

Top module: `dual_fmt_serializer`

## Requirements
- R1: With `half_mode` low, all of `tx_data[9:0]` is sampled in the cycle where `ref_rise` is high. Values on `tx_data` in the other cycles of the word period, the mid-word cycle included, never reach the serial stream.
- R2: With `half_mode` high, `tx_data[4:0]` in the `ref_rise` cycle becomes word bits 4..0. `tx_data[4:0]` in the fifth cycle after that strobe becomes word bits 9..5. `tx_data[9:5]` is ignored in this format.
- R3: A word loaded into the shift register appears on the serial output least significant bit first. Bit i is present in the i-th cycle after the load edge, with bit 0 present right after the load.
- R4: In full-word format, take a word sampled at strobe edge t. Its bit 0 is on the serial output after edge t+10 and its bit 9 after edge t+19, provided the next strobe comes exactly ten cycles later.
- R5: In half-word format, take a word whose low half is sampled at strobe edge t. Its bit 0 is on the serial output after edge t+20 and its bit 9 after edge t+29, with strobes every ten cycles.
- R6: While `loop_en` is high, from the next cycle on, `ser_oe` and `ser_out` are 0 and `loop_rx` carries the serial stream with the same timing. While `loop_en` is low, `loop_rx` is 0.
- R7: While `enable` is low, from the next cycle on, `ser_oe`, `ser_out` and `loop_rx` are all 0. The shift register keeps shifting, so re-enabling in the middle of a word resumes that word at the bit now due.
- R8: A synchronous active-high reset clears the shift register and the staged words and drives `ser_out`, `ser_oe` and `loop_rx` to 0. After release the serial output stays low until a non-zero word is loaded.
- R9: A load happens only on a `ref_rise` cycle. Once a word has left, the serial output is 0 until the next strobe, even when a word is already staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, ten times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| ref_rise | input | 1 | One-cycle strobe marking the reference clock rising edge |
| tx_data | input | 10 | Parallel encoded symbol (low five bits only in half-word format) |
| half_mode | input | 1 | 0 selects full-word format, 1 selects half-word format |
| loop_en | input | 1 | Routes the serial stream to `loop_rx` and turns off the line driver |
| enable | input | 1 | 0 turns off all serial outputs |
| ser_out | output | 1 | Serial line data (0 while the driver is off) |
| ser_oe | output | 1 | Line driver enable; 0 stands for high impedance |
| loop_rx | output | 1 | Serial stream delivered to the receive side in loopback |

## Verification
The bench builds the block with its default 10-bit word, so the mid-word sample point is five cycles after the strobe. This puts both format latencies, 10/19 and 20/29 cycles, within reach of direct per-cycle observation. Word streams in both formats use distinct garbage on the lines and phases that must be ignored. The bench also checks a staged word left waiting with no strobe, enable dropped and restored partway through a word, and a reset that lands mid-word while a word is staged behind it.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic {
    FMT_FULL = 1'b0,
    FMT_HALF = 1'b1
  } fmt_e;
endpackage

// File: rtl/sertx_phase.sv
module sertx_phase #(
  parameter int WORD_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  output logic fall_stb
);
  localparam int PH_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam int HALF = WORD_W / 2;

  logic [PH_W-1:0] ph_q;

  // Count bit times since the last strobe; wraps once per word period.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
    end else if (ref_rise) begin
      ph_q <= PH_W'(1);
    end else if (ph_q == PH_W'(WORD_W - 1)) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + PH_W'(1);
    end
  end

  // Mid-word point stands for the opposite reference clock edge.
  assign fall_stb = (ph_q == PH_W'(HALF)) && !ref_rise;

  p_mid_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
    ref_rise |=> !fall_stb);
endmodule

// File: rtl/sertx_capture.sv
module sertx_capture
  import ser_tx_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_rise,
  input  logic              fall_stb,
  input  fmt_e              fmt,
  input  logic [WORD_W-1:0] tx_data,
  output logic [WORD_W-1:0] ready_word
);
  localparam int HALF = WORD_W / 2;
  localparam int HI_W = WORD_W - HALF;

  logic [HALF-1:0]   lo_q;
  logic [WORD_W-1:0] asm_q;
  logic [WORD_W-1:0] ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      asm_q   <= '0;
      ready_q <= '0;
    end else begin
      if (ref_rise) begin
        if (fmt == FMT_FULL) begin
          ready_q <= tx_data;
        end else begin
          lo_q    <= tx_data[HALF-1:0];
          ready_q <= asm_q;  // complete word from the previous period
        end
      end
      if (fall_stb && fmt == FMT_HALF) begin
        asm_q <= {tx_data[HI_W-1:0], lo_q};
      end
    end
  end

  assign ready_word = ready_q;

  p_full_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && fmt == FMT_FULL) |=> ready_q == $past(tx_data));
  p_hold_between_r1: assert property (@(posedge clk) disable iff (rst)
    !ref_rise |=> ready_q == $past(ready_q));
  p_half_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (fall_stb && fmt == FMT_HALF) |=> asm_q[WORD_W-1:HALF] == $past(tx_data[HI_W-1:0]));
  p_half_lower_r2: assert property (@(posedge clk) disable iff (rst)
    (fall_stb && fmt == FMT_HALF) |=> asm_q[HALF-1:0] == $past(lo_q));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              enable,
  input  logic              loop_en,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              loop_rx
);
  logic [WORD_W-1:0] sh_q;
  logic              oe_q;
  logic              lb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      oe_q <= 1'b0;
      lb_q <= 1'b0;
    end else begin
      sh_q <= load ? word : {1'b0, sh_q[WORD_W-1:1]};
      oe_q <= enable && !loop_en;
      lb_q <= enable && loop_en;
    end
  end

  assign ser_out = sh_q[0] & oe_q;
  assign ser_oe  = oe_q;
  assign loop_rx = sh_q[0] & lb_q;

  p_shift_lsb_first_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> sh_q == ($past(sh_q) >> 1));
  p_load_word_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> sh_q == $past(word));
  p_loop_driver_off_r6: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> (!ser_oe && !ser_out));
  p_loop_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> !loop_rx);
  p_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!ser_oe && !ser_out && !loop_rx));
endmodule

// File: rtl/dual_fmt_serializer.sv
module dual_fmt_serializer #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_rise,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              half_mode,
  input  logic              loop_en,
  input  logic              enable,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              loop_rx
);
  import ser_tx_pkg::*;

  logic              fall_stb;
  logic [WORD_W-1:0] ready_word;
  fmt_e              fmt;

  assign fmt = half_mode ? FMT_HALF : FMT_FULL;

  sertx_phase #(.WORD_W(WORD_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (ref_rise),
    .fall_stb (fall_stb)
  );

  sertx_capture #(.WORD_W(WORD_W)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .ref_rise   (ref_rise),
    .fall_stb   (fall_stb),
    .fmt        (fmt),
    .tx_data    (tx_data),
    .ready_word (ready_word)
  );

  sertx_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .load    (ref_rise),
    .word    (ready_word),
    .enable  (enable),
    .loop_en (loop_en),
    .ser_out (ser_out),
    .ser_oe  (ser_oe),
    .loop_rx (loop_rx)
  );
endmodule

// File: tb/dual_fmt_serializer_bench.sv
module dual_fmt_serializer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_rise = 1'b0;
  logic [9:0] tx_data = '0;
  logic       half_mode = 1'b0;
  logic       loop_en = 1'b0;
  logic       enable = 1'b1;
  logic       ser_out, ser_oe, loop_rx;

  int checks = 0;
  int errors = 0;
  bit outlog [512];
  bit lblog  [512];
  bit oelog  [512];
  logic [9:0] wds [8];

  always #2 clk = ~clk;

  dual_fmt_serializer #(.WORD_W(10)) u_dual_fmt_serializer (
    .clk(clk), .rst(rst), .ref_rise(ref_rise), .tx_data(tx_data),
    .half_mode(half_mode), .loop_en(loop_en), .enable(enable),
    .ser_out(ser_out), .ser_oe(ser_oe), .loop_rx(loop_rx)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic record(input int j);
    outlog[j] = ser_out;
    lblog[j]  = loop_rx;
    oelog[j]  = ser_oe;
  endtask

  function automatic int count_ones(input int which, input int lo, input int hi);
    int n = 0;
    for (int j = lo; j <= hi; j++) begin
      if (which == 0 && outlog[j]) n++;
      if (which == 1 && lblog[j])  n++;
      if (which == 2 && oelog[j])  n++;
    end
    return n;
  endfunction

  // R8: reset state and quiet line after release
  task automatic test_reset();
    rst = 1'b1; enable = 1'b1; loop_en = 1'b0; half_mode = 1'b0;
    ref_rise = 1'b0; tx_data = '0;
    repeat (3) tick();
    check("R8", "ser_out in reset", int'(ser_out), 0);
    check("R8", "ser_oe in reset", int'(ser_oe), 0);
    check("R8", "loop_rx in reset", int'(loop_rx), 0);
    rst = 1'b0;
    tx_data = 10'h3FF;
    for (int j = 0; j < 12; j++) begin
      tick();
      record(j);
    end
    tx_data = '0;
    check("R7", "ser_oe after release", count_ones(2, 0, 11), 12);
    check("R8", "line low before first load", count_ones(0, 0, 11), 0);
  endtask

  // R1 R2 R3 R4 R5 R6: stream of words in the chosen format
  task automatic run_stream(input bit ddr, input bit lb, input int n, input string tag);
    int base;
    logic [9:0] act, wv;
    half_mode = ddr; loop_en = lb;
    tick(); tick();
    for (int j = 0; j < (n + 3) * 10; j++) begin
      int k = j / 10;
      int p = j % 10;
      wv = (k < n) ? wds[k] : 10'h000;
      ref_rise = (p == 0);
      if (ddr) begin
        if (p == 0)      tx_data = {5'b10110, wv[4:0]};
        else if (p == 5) tx_data = {5'b01001, wv[9:5]};
        else             tx_data = 10'h2D3 ^ 10'(j);
      end else begin
        tx_data = (p == 0) ? wv : ~wv;
      end
      tick();
      record(j);
    end
    ref_rise = 1'b0; tx_data = '0;
    for (int k = 0; k < n; k++) begin
      base = 10 * k + (ddr ? 20 : 10);
      for (int i = 0; i < 10; i++) act[i] = lb ? lblog[base + i] : outlog[base + i];
      check(tag, $sformatf("word %0d", k), int'(act), int'(wds[k]));
    end
    if (lb) begin
      check("R6", "ser_out during loopback", count_ones(0, 0, (n + 3) * 10 - 1), 0);
      check("R6", "ser_oe during loopback", count_ones(2, 0, (n + 3) * 10 - 1), 0);
    end else begin
      check("R6", "loop_rx without loopback", count_ones(1, 0, (n + 3) * 10 - 1), 0);
    end
    loop_en = 1'b0;
  endtask

  // R9: staged word waits for a strobe
  task automatic test_gap();
    half_mode = 1'b0; loop_en = 1'b0;
    tick(); tick();
    for (int j = 0; j < 40; j++) begin
      ref_rise = (j == 0 || j == 10);
      tx_data = ref_rise ? 10'h3FF : 10'h155;
      tick();
      record(j);
    end
    ref_rise = 1'b0; tx_data = '0;
    check("R9", "word bits out", count_ones(0, 10, 19), 10);
    check("R9", "no load without strobe", count_ones(0, 20, 39), 0);
  endtask

  // R7: enable dropped and restored mid-word
  task automatic test_enable();
    half_mode = 1'b0; loop_en = 1'b0; enable = 1'b0;
    tick();
    for (int j = 0; j < 25; j++) begin
      ref_rise = (j == 0 || j == 10);
      tx_data = ref_rise ? 10'h3FF : 10'h000;
      if (j == 15) enable = 1'b1;
      tick();
      record(j);
    end
    ref_rise = 1'b0; tx_data = '0;
    check("R7", "ser_oe while disabled", count_ones(2, 0, 14), 0);
    check("R7", "ser_out while disabled", count_ones(0, 10, 14), 0);
    check("R7", "loop_rx while disabled", count_ones(1, 0, 14), 0);
    check("R7", "resumed bits 5..9", count_ones(0, 15, 19), 5);
  endtask

  // R8: reset mid-word clears shift and staged word
  task automatic test_mid_reset();
    half_mode = 1'b0; loop_en = 1'b0; enable = 1'b1;
    tick();
    for (int j = 0; j < 30; j++) begin
      ref_rise = (j == 0 || j == 10 || j == 20);
      tx_data = (j == 0 || j == 10) ? 10'h3FF : 10'h000;
      rst = (j == 13);
      tick();
      record(j);
    end
    rst = 1'b0; ref_rise = 1'b0; tx_data = '0;
    check("R8", "bits before reset", count_ones(0, 10, 12), 3);
    check("R8", "line low after reset", count_ones(0, 13, 29), 0);
    check("R8", "ser_oe cleared by reset", int'(oelog[13]), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wds[0] = 10'h0FA; wds[1] = 10'h305; wds[2] = 10'h17C; wds[3] = 10'h283;
    wds[4] = 10'h3C1; wds[5] = 10'h02B; wds[6] = 10'h155; wds[7] = 10'h2AA;
    test_reset();
    run_stream(1'b0, 1'b0, 6, "R1 R3 R4");
    run_stream(1'b1, 1'b0, 6, "R2 R3 R5");
    run_stream(1'b0, 1'b1, 4, "R6 R4");
    run_stream(1'b1, 1'b1, 3, "R6 R5");
    test_gap();
    test_enable();
    test_mid_reset();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule